// File: doc/BRIEF.md
# Multi-Rail Supply Failure Supervisor

This block watches a group of DC supply rails. Each rail reports one digitized fault bit from an external comparator. Closing the power switch turns on the main supply relay at once. The block then waits through a fixed settling window so the rails can come up, and it ignores every fault bit during that window. After the window it samples all fault bits on a periodic strobe. The first strobe that finds any failed rail drops the relay and trips the block into a shutdown state. A per-rail flag vector then shows which rails were caught failing.

The trip and its flags are held until the power switch is opened, which returns the block to idle. The rail count, the settling window and the strobe period are all parameters given in system clock cycles. The fault inputs are asynchronous, so they pass through a resynchronizer before they are sampled. The switch input is expected to be debounced and synchronous to the clock.

Top module: `rail_supervisor`

## Requirements
- R1: While the block is not tripped, `relay_en_o` equals `pwr_sw_i` in the same cycle, with no register in the path. In the tripped state `relay_en_o` is 0.
- R2: After reset, `shutdown_o` is 0 and `fail_flags_o` is all zeros.
- R3: The first clock edge that sees `pwr_sw_i` high starts a settling window of `SETTLE_CYCLES` cycles. Fault bits seen during this window cannot cause a trip.
- R4: After the settling window, a strobe samples the resynchronized fault bits every `SAMPLE_PERIOD` cycles. The first sample falls `SAMPLE_PERIOD` cycles after monitoring starts. A fault must be stable for two cycles before a strobe to be seen.
- R5: A fault bit of 0 means the rail is healthy. While every sampled bit is 0, the relay stays on and `shutdown_o` stays 0.
- R6: If any sampled bit is 1, then from the strobe edge onward `relay_en_o` is 0 and `shutdown_o` is 1.
- R7: Bit i of `fail_flags_o` is the sampled fault bit of rail i, and several bits may be set at once. The flags hold through the whole trip, even after the inputs clear.
- R8: Opening the switch returns the block to idle on the next edge. `shutdown_o` and `fail_flags_o` go back to 0, and a later closure starts a fresh settling window.
- R9: If the switch opens in the same cycle as a strobe that sees a fault, the opening wins. The block goes idle with no trip and all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_sw_i | input | 1 | Power switch, 1 = closed |
| rail_fault_i | input | N_RAILS | Raw fault bit per rail, 1 = failed |
| relay_en_o | output | 1 | Main supply relay enable |
| shutdown_o | output | 1 | Tripped state indicator |
| fail_flags_o | output | N_RAILS | Failed-rail flags captured at the trip |

## Verification
Two functions can fall in the same cycle: the sample strobe capturing a failed rail, and the switch opening that sends the block idle. The bench provokes this by holding a fault on one rail through the resynchronizer. It then opens the switch in the exact cycle before the strobe edge, a cycle computed from the settling length and strobe period. A correct block drops the relay at once and, after that edge, shows no trip and all flags clear. A second closure then confirms that no stale trip survives.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;
   typedef enum logic [1:0] {
      SUP_OFF    = 2'd0,
      SUP_SETTLE = 2'd1,
      SUP_WATCH  = 2'd2,
      SUP_TRIP   = 2'd3
   } sup_state_e;
endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (W < 1)      $error("rail_sync: W must be at least 1");
      if (STAGES < 2) $error("rail_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rail_interval_timer.sv
module rail_interval_timer #(
   parameter int LIMIT    = 8,
   parameter bit ONE_SHOT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   initial begin
      if (LIMIT < 2) $error("rail_interval_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;
   logic          at_last;

   assign at_last = (cnt_q == LAST);

   if (ONE_SHOT) begin : g_oneshot
      always_comb cnt_d = at_last ? cnt_q : cnt_q + 1'b1;
   end else begin : g_periodic
      always_comb cnt_d = at_last ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else             cnt_q <= cnt_d;
   end

   assign done_o = run_i && at_last;

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);                                                   // R4
   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));                                        // R4
endmodule

// File: rtl/rail_sup_ctrl.sv
module rail_sup_ctrl
   import rail_sup_pkg::*;
#(
   parameter int N_RAILS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_i,
   input  logic               settle_done_i,
   input  logic               strobe_i,
   input  logic [N_RAILS-1:0] fault_i,
   output sup_state_e         state_o,
   output logic [N_RAILS-1:0] flags_o
);
   sup_state_e         state_q, state_d;
   logic [N_RAILS-1:0] flags_q;
   logic               capture;

   assign capture = (state_q == SUP_WATCH) && sw_i && strobe_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SUP_OFF:    if (sw_i) state_d = SUP_SETTLE;
         SUP_SETTLE: if (!sw_i) state_d = SUP_OFF;
                     else if (settle_done_i) state_d = SUP_WATCH;
         SUP_WATCH:  if (!sw_i) state_d = SUP_OFF;
                     else if (strobe_i && (|fault_i)) state_d = SUP_TRIP;
         SUP_TRIP:   if (!sw_i) state_d = SUP_OFF;
         default:    state_d = SUP_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SUP_OFF;
         flags_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_d == SUP_OFF) flags_q <= '0;
         else if (capture)       flags_q <= fault_i;
      end
   end

   assign state_o = state_q;
   assign flags_o = flags_q;

   AST_WATCH_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == SUP_WATCH) |-> $past(state_q == SUP_SETTLE));    // R3
   AST_NO_FLAGS_BEFORE_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SUP_SETTLE) |-> (flags_q == '0));                     // R3
   AST_TRIP_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SUP_TRIP) |-> (|flags_q));                            // R7
   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == SUP_TRIP) && $past(state_q == SUP_TRIP)) |-> $stable(flags_q)); // R7
   AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SUP_OFF) |-> (flags_q == '0));                        // R8
   AST_OPEN_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_i |=> (state_q == SUP_OFF));                                  // R9
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
   import rail_sup_pkg::*;
#(
   parameter int N_RAILS       = 4,
   parameter int SETTLE_CYCLES = 125_000_000,
   parameter int SAMPLE_PERIOD = 250_000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_sw_i,
   input  logic [N_RAILS-1:0] rail_fault_i,
   output logic               relay_en_o,
   output logic               shutdown_o,
   output logic [N_RAILS-1:0] fail_flags_o
);
   initial begin
      if (N_RAILS < 1)       $error("rail_supervisor: N_RAILS must be at least 1");
      if (SETTLE_CYCLES < 2) $error("rail_supervisor: SETTLE_CYCLES must be at least 2");
      if (SAMPLE_PERIOD < 2) $error("rail_supervisor: SAMPLE_PERIOD must be at least 2");
   end

   logic [N_RAILS-1:0] fault_sync;
   logic               settle_done;
   logic               strobe;
   sup_state_e         state;

   rail_sync #(.W(N_RAILS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rail_fault_i),
      .q_o   (fault_sync)
   );

   rail_interval_timer #(.LIMIT(SETTLE_CYCLES), .ONE_SHOT(1'b1)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == SUP_SETTLE),
      .done_o (settle_done)
   );

   rail_interval_timer #(.LIMIT(SAMPLE_PERIOD), .ONE_SHOT(1'b0)) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == SUP_WATCH),
      .done_o (strobe)
   );

   rail_sup_ctrl #(.N_RAILS(N_RAILS)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .sw_i          (pwr_sw_i),
      .settle_done_i (settle_done),
      .strobe_i      (strobe),
      .fault_i       (fault_sync),
      .state_o       (state),
      .flags_o       (fail_flags_o)
   );

   assign shutdown_o = (state == SUP_TRIP);
   assign relay_en_o = pwr_sw_i && !shutdown_o;

   AST_TRIP_RELAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |-> !relay_en_o);                                      // R6
   AST_OPEN_RELAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_sw_i |-> !relay_en_o);                                       // R1
   AST_TRIP_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown_o) |-> $past(strobe));                             // R4
endmodule

// File: tb/rail_supervisor_tb.sv
module rail_supervisor_tb;
   localparam int NR     = 4;
   localparam int SETTLE = 20;
   localparam int PERIOD = 8;

   typedef struct {
      string      tag;
      logic       relay;
      logic       sd;
      logic [3:0] flags;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_sw = 1'b0;
   logic [NR-1:0] fault = '0;
   logic          relay_en, shutdown;
   logic [NR-1:0] flags;

   int   checks = 0;
   int   failures = 0;
   bit   finished = 1'b0;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   rail_supervisor #(
      .N_RAILS(NR), .SETTLE_CYCLES(SETTLE), .SAMPLE_PERIOD(PERIOD), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_sw_i(pwr_sw), .rail_fault_i(fault),
      .relay_en_o(relay_en), .shutdown_o(shutdown), .fail_flags_o(flags)
   );

   task automatic to_neg(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic expect_now(input string tag, input logic r, input logic s, input logic [3:0] f);
      exp_t e;
      e.tag = tag; e.relay = r; e.sd = s; e.flags = f;
      exp_q.push_back(e);
   endtask

   // monitor: pops expectations pushed one time unit earlier
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (relay_en !== e.relay || shutdown !== e.sd || flags !== e.flags) begin
               failures++;
               $display("FAIL %s: relay=%b sd=%b flags=%b expected relay=%b sd=%b flags=%b",
                        e.tag, relay_en, shutdown, flags, e.relay, e.sd, e.flags);
            end
         end
      end
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      to_neg(2);
      expect_now("R2 reset state", 1'b0, 1'b0, 4'b0000);
      to_neg(1);
      rst_n = 1'b1;

      // Scenario A: settling ignores faults, single-rail trip, hold, release
      to_neg(2);
      pwr_sw = 1'b1;
      expect_now("R1 relay follows switch at once", 1'b1, 1'b0, 4'b0000);
      to_neg(5);  fault = 4'b0010;
      to_neg(10); fault = 4'b0000;
      expect_now("R3 no trip while settling", 1'b1, 1'b0, 4'b0000);
      to_neg(14);                                // after first strobe edge
      expect_now("R3 R5 settling fault ignored, healthy sample", 1'b1, 1'b0, 4'b0000);
      fault = 4'b0100;
      to_neg(7);                                 // just before second strobe
      expect_now("R4 no capture between strobes", 1'b1, 1'b0, 4'b0000);
      to_neg(1);
      expect_now("R6 R7 trip on rail 2", 1'b0, 1'b1, 4'b0100);
      fault = 4'b0000;
      to_neg(13);
      expect_now("R7 flags held after fault clears", 1'b0, 1'b1, 4'b0100);
      pwr_sw = 1'b0;
      expect_now("R1 relay off on open", 1'b0, 1'b1, 4'b0100);
      to_neg(1);
      expect_now("R8 open clears trip and flags", 1'b0, 1'b0, 4'b0000);

      // Scenario B: several rails fail together on the first strobe
      to_neg(3);
      pwr_sw = 1'b1;
      to_neg(25); fault = 4'b1011;
      to_neg(3);
      expect_now("R4 first strobe not yet", 1'b1, 1'b0, 4'b0000);
      to_neg(1);
      expect_now("R7 multi-rail flags", 1'b0, 1'b1, 4'b1011);
      pwr_sw = 1'b0; fault = 4'b0000;
      to_neg(1);
      expect_now("R8 idle after multi-rail trip", 1'b0, 1'b0, 4'b0000);

      // Scenario C: switch opens in the strobe cycle
      to_neg(3);
      pwr_sw = 1'b1;
      to_neg(30); fault = 4'b0001;
      to_neg(6);  pwr_sw = 1'b0;
      expect_now("R9 relay drops on open", 1'b0, 1'b0, 4'b0000);
      to_neg(1);
      expect_now("R9 open wins over strobe", 1'b0, 1'b0, 4'b0000);
      to_neg(5);
      expect_now("R9 still idle", 1'b0, 1'b0, 4'b0000);
      fault = 4'b0000;
      to_neg(2);
      pwr_sw = 1'b1;
      to_neg(40);
      expect_now("R8 R5 fresh closure runs clean", 1'b1, 1'b0, 4'b0000);

      to_neg(2);
      finish_run();
   end
endmodule